// File: doc/BRIEF.md
# Outstanding Miss Request Tracker

This block keeps account of cache-line requests that a multithreaded core has handed to its cache controller and that have not yet come back. Each hardware thread owns two small tables, one for reads (loads and instruction fetches) and one for writes (stores and atomics). Every entry is keyed by its line address. The issuer presents a request with a thread number, type flags, a byte address and a prefetch flag. The block answers with a ready signal that tells the issuer whether the request should be sent now.

Completions come back from the controller as a line number on a read channel and on a write channel. For each completion the block retires the matching entry that has waited longest, across all threads. One cycle later it reports which thread and which request kind finished, unless that request was a prefetch. A running count of live entries caps how many requests are in flight. An age watchdog raises a sticky deadlock flag when a request stays pending too long. A completion that matches nothing raises a sticky protocol-error flag.

Top module: `miss_tracker`

## Requirements
- R1: The request kind is decoded with fixed priority: fetch flag gives instruction fetch (kind code 1), otherwise lock or swap gives atomic (code 3), otherwise read gives load (code 0), otherwise write gives store (code 2). With no flag set, nothing is inserted. Loads and fetches go to the issuing thread's read table. Stores and atomics go to its write table.
- R2: The line address is the byte address with its low OFFSET_W (6) bits cleared and shifted out. Addresses inside one 64-byte line refer to the same entry, and completions carry this line number.
- R3: `iss_ready` is low while `outstanding` equals MAX_OUT, and also while the table the decoded request would enter has no free slot. An insert that needs a new slot is dropped when the count is at MAX_OUT or the table is full.
- R4: `iss_ready` is low whenever any thread's read or write table holds a live entry for the presented line.
- R5: `iss_ready` is advisory; the block acts on every `iss_valid`. An insert that finds a live entry for its line in the target table overwrites that entry, and the count stays the same. Otherwise the insert takes a free slot and the count rises by one.
- R6: A completion searches the table of its kind (read or write) in every thread. It retires the matching entry with the earliest issue time, with a tie going to the lowest thread, and the count falls by one. The next cycle, the response valid of that channel is high with the owning thread and the kind code.
- R7: Retiring a prefetch entry frees it and lowers the count but sends no response.
- R8: An insert while the watchdog is idle arms it for DL_THRESH cycles. When the period ends, any live entry whose age is DL_THRESH or more sets the sticky `deadlock` output. The watchdog then re-arms if requests remain and goes idle if none remain.
- R9: A completion with no matching entry in the tables of its kind sets the sticky `proto_err` output, changes no entry and no count, and sends no response.
- R10: After reset, `outstanding` is 0, `iss_ready` is 1, both response valids are 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Request presented this cycle |
| iss_thread | input | TID_W | Issuing thread |
| iss_fetch | input | 1 | Instruction fetch flag |
| iss_lock | input | 1 | Locked access flag |
| iss_swap | input | 1 | Swap access flag |
| iss_rd | input | 1 | Read flag |
| iss_wr | input | 1 | Write flag |
| iss_addr | input | ADDR_W | Byte address |
| iss_pf | input | 1 | Request is a prefetch |
| iss_ready | output | 1 | Request may be sent now |
| rd_cpl_valid | input | 1 | Read-side completion |
| rd_cpl_line | input | LINE_W | Line number of read completion |
| wr_cpl_valid | input | 1 | Write-side completion |
| wr_cpl_line | input | LINE_W | Line number of write completion |
| rd_resp_valid | output | 1 | Read-side response to requester |
| rd_resp_thread | output | TID_W | Thread of read response |
| rd_resp_kind | output | 2 | Kind code of read response |
| wr_resp_valid | output | 1 | Write-side response to requester |
| wr_resp_thread | output | TID_W | Thread of write response |
| wr_resp_kind | output | 2 | Kind code of write response |
| outstanding | output | CNT_W | Live entries in all tables |
| deadlock | output | 1 | Sticky age-watchdog fault |
| proto_err | output | 1 | Sticky unmatched-completion fault |

## Verification
Every combination of the five type flags is issued from alternating threads. Each request is completed on the channel its expected kind selects, so a wrong priority or a wrong table shows up as a wrong kind, a missing response or a protocol error. Same-line requests from two threads are issued in both thread orders, which separates oldest-first retirement from lowest-index selection. A repeated insert that flips the prefetch bit shows that the entry was overwritten and not duplicated. Deadlock timing is checked with an entry held across exactly one period, with a younger entry that only trips after the re-arm, and with an early retire that must never trip.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFFSET_W = 6;
    localparam int LINE_W   = ADDR_W - OFFSET_W;
    localparam int TS_W     = 32;

    typedef enum logic [1:0] {
        K_LOAD   = 2'd0,
        K_IFETCH = 2'd1,
        K_STORE  = 2'd2,
        K_ATOMIC = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] tag;
        req_kind_e         kind;
        logic              pf;
        logic [TS_W-1:0]   ts;
    } slot_t;

    typedef struct packed {
        logic      ok;
        req_kind_e kind;
    } decode_t;

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] cleared;
        cleared = a & ~ADDR_W'((64'd1 << OFFSET_W) - 64'd1);
        return LINE_W'(cleared >> OFFSET_W);
    endfunction

    function automatic decode_t classify(input logic fetch, input logic lock,
                                         input logic swap, input logic rd,
                                         input logic wr);
        decode_t d;
        d.ok = 1'b1;
        if (fetch)            d.kind = K_IFETCH;
        else if (lock | swap) d.kind = K_ATOMIC;
        else if (rd)          d.kind = K_LOAD;
        else if (wr)          d.kind = K_STORE;
        else begin
            d.ok   = 1'b0;
            d.kind = K_LOAD;
        end
        return d;
    endfunction

    function automatic logic is_write_kind(input req_kind_e k);
        return (k == K_STORE) || (k == K_ATOMIC);
    endfunction

endpackage

// File: rtl/mt_table.sv
module mt_table
    import mt_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_en,
    input  logic [LINE_W-1:0] ins_tag,
    input  req_kind_e         ins_kind,
    input  logic              ins_pf,
    input  logic              ins_room,
    input  logic [TS_W-1:0]   now,
    input  logic [LINE_W-1:0] cpl_tag,
    input  logic [ENTRIES-1:0] ret_vec,
    output logic [ENTRIES-1:0] iss_match,
    output logic [ENTRIES-1:0] cpl_match,
    output logic              took,
    output logic              allocated,
    output logic              full,
    output logic [ENTRIES-1:0] live,
    output logic [TS_W-1:0]   ts_o   [ENTRIES],
    output req_kind_e         kind_o [ENTRIES],
    output logic [ENTRIES-1:0] pf_o
);

    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] wr_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        slot_t s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else if (ret_vec[e]) begin
                s_q.valid <= 1'b0;
            end else if (wr_vec[e]) begin
                s_q <= '{valid: 1'b1, tag: ins_tag, kind: ins_kind,
                         pf: ins_pf, ts: now};
            end
        end

        assign iss_match[e] = s_q.valid && (s_q.tag == ins_tag);
        assign cpl_match[e] = s_q.valid && (s_q.tag == cpl_tag);
        assign free_vec[e]  = !s_q.valid;
        assign live[e]      = s_q.valid;
        assign ts_o[e]      = s_q.ts;
        assign kind_o[e]    = s_q.kind;
        assign pf_o[e]      = s_q.pf;
    end

    assign full = ~|free_vec;

    // Overwrite an existing entry for the line, else claim the lowest free slot.
    always_comb begin
        wr_vec    = '0;
        allocated = 1'b0;
        if (ins_en) begin
            if (|iss_match) begin
                wr_vec = iss_match & (~iss_match + ENTRIES'(1));
            end else if (ins_room && |free_vec) begin
                wr_vec    = free_vec & (~free_vec + ENTRIES'(1));
                allocated = 1'b1;
            end
        end
    end

    assign took = |wr_vec;

    p_one_per_line_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(iss_match));

    p_retire_live_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_vec & free_vec) == '0);

    p_alloc_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (allocated && (ret_vec == '0)) |=> $countones(live) == $countones($past(live)) + 1);

endmodule

// File: rtl/mt_oldest.sv
module mt_oldest
    import mt_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]    cand,
    input  logic [TS_W-1:0] age [N],
    output logic            found,
    output logic [N-1:0]    pick
);

    logic [TS_W-1:0] best;

    // Strictly greater age wins, so equal ages keep the lowest index.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || (age[i] > best))) begin
                found   = 1'b1;
                pick    = '0;
                pick[i] = 1'b1;
                best    = age[i];
            end
        end
    end

endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog
    import mt_pkg::*;
#(
    parameter int N      = 16,
    parameter int THRESH = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm_req,
    input  logic            busy_next,
    input  logic [N-1:0]    live,
    input  logic [TS_W-1:0] age [N],
    output logic            deadlock
);

    localparam int TMR_W = $clog2(THRESH + 1);

    logic             armed;
    logic [TMR_W-1:0] tmr;
    logic             fire;
    logic             stale;

    assign fire = armed && (tmr == '0);

    always_comb begin
        stale = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (live[i] && (age[i] >= TS_W'(THRESH))) stale = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            tmr      <= '0;
            deadlock <= 1'b0;
        end else begin
            if (fire && stale) deadlock <= 1'b1;
            if (!armed) begin
                if (arm_req) begin
                    armed <= 1'b1;
                    tmr   <= TMR_W'(THRESH - 1);
                end
            end else if (fire) begin
                if (busy_next) tmr   <= TMR_W'(THRESH - 1);
                else           armed <= 1'b0;
            end else begin
                tmr <= tmr - TMR_W'(1);
            end
        end
    end

    p_tmr_range_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (tmr < TMR_W'(THRESH)));

    p_dl_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);

    p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && busy_next) |=> armed);

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
    import mt_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int ENTRIES     = 4,
    parameter int MAX_OUT     = 6,
    parameter int DL_THRESH   = 1000,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [TID_W-1:0]  iss_thread,
    input  logic              iss_fetch,
    input  logic              iss_lock,
    input  logic              iss_swap,
    input  logic              iss_rd,
    input  logic              iss_wr,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              iss_pf,
    output logic              iss_ready,
    input  logic              rd_cpl_valid,
    input  logic [LINE_W-1:0] rd_cpl_line,
    input  logic              wr_cpl_valid,
    input  logic [LINE_W-1:0] wr_cpl_line,
    output logic              rd_resp_valid,
    output logic [TID_W-1:0]  rd_resp_thread,
    output logic [1:0]        rd_resp_kind,
    output logic              wr_resp_valid,
    output logic [TID_W-1:0]  wr_resp_thread,
    output logic [1:0]        wr_resp_kind,
    output logic [CNT_W-1:0]  outstanding,
    output logic              deadlock,
    output logic              proto_err
);

    localparam int NSLOT = NUM_THREADS * ENTRIES;

    logic [TS_W-1:0]   now_q;
    decode_t           dec;
    logic              dec_is_wr;
    logic [LINE_W-1:0] iss_line;
    logic              room;

    logic [NSLOT-1:0] rd_iss_m, wr_iss_m, rd_cpl_m, wr_cpl_m;
    logic [NSLOT-1:0] rd_ret, wr_ret, rd_live, wr_live, rd_pf, wr_pf;
    logic [NUM_THREADS-1:0] rd_took, wr_took, rd_alloc, wr_alloc, rd_full, wr_full;
    logic [TS_W-1:0]  rd_ts   [NUM_THREADS][ENTRIES];
    logic [TS_W-1:0]  wr_ts   [NUM_THREADS][ENTRIES];
    req_kind_e        rd_kind [NUM_THREADS][ENTRIES];
    req_kind_e        wr_kind [NUM_THREADS][ENTRIES];
    logic [TS_W-1:0]  rd_age  [NSLOT];
    logic [TS_W-1:0]  wr_age  [NSLOT];
    logic [TS_W-1:0]  all_age [2*NSLOT];

    assign dec       = classify(iss_fetch, iss_lock, iss_swap, iss_rd, iss_wr);
    assign dec_is_wr = is_write_kind(dec.kind);
    assign iss_line  = line_of(iss_addr);
    assign room      = outstanding < CNT_W'(MAX_OUT);

    // One read table and one write table per hardware thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic mine;
        assign mine = iss_valid && dec.ok && (iss_thread == TID_W'(t));

        mt_table #(.ENTRIES(ENTRIES)) u_rd (
            .clk       (clk),
            .rst       (rst),
            .ins_en    (mine && !dec_is_wr),
            .ins_tag   (iss_line),
            .ins_kind  (dec.kind),
            .ins_pf    (iss_pf),
            .ins_room  (room),
            .now       (now_q),
            .cpl_tag   (rd_cpl_line),
            .ret_vec   (rd_ret[t*ENTRIES +: ENTRIES]),
            .iss_match (rd_iss_m[t*ENTRIES +: ENTRIES]),
            .cpl_match (rd_cpl_m[t*ENTRIES +: ENTRIES]),
            .took      (rd_took[t]),
            .allocated (rd_alloc[t]),
            .full      (rd_full[t]),
            .live      (rd_live[t*ENTRIES +: ENTRIES]),
            .ts_o      (rd_ts[t]),
            .kind_o    (rd_kind[t]),
            .pf_o      (rd_pf[t*ENTRIES +: ENTRIES])
        );

        mt_table #(.ENTRIES(ENTRIES)) u_wr (
            .clk       (clk),
            .rst       (rst),
            .ins_en    (mine && dec_is_wr),
            .ins_tag   (iss_line),
            .ins_kind  (dec.kind),
            .ins_pf    (iss_pf),
            .ins_room  (room),
            .now       (now_q),
            .cpl_tag   (wr_cpl_line),
            .ret_vec   (wr_ret[t*ENTRIES +: ENTRIES]),
            .iss_match (wr_iss_m[t*ENTRIES +: ENTRIES]),
            .cpl_match (wr_cpl_m[t*ENTRIES +: ENTRIES]),
            .took      (wr_took[t]),
            .allocated (wr_alloc[t]),
            .full      (wr_full[t]),
            .live      (wr_live[t*ENTRIES +: ENTRIES]),
            .ts_o      (wr_ts[t]),
            .kind_o    (wr_kind[t]),
            .pf_o      (wr_pf[t*ENTRIES +: ENTRIES])
        );
    end

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                rd_age[t*ENTRIES + e]          = now_q - rd_ts[t][e];
                wr_age[t*ENTRIES + e]          = now_q - wr_ts[t][e];
                all_age[t*ENTRIES + e]         = now_q - rd_ts[t][e];
                all_age[NSLOT + t*ENTRIES + e] = now_q - wr_ts[t][e];
            end
        end
    end

    // Ready: capacity left, line idle in every thread, target table not full.
    logic tgt_full;
    assign tgt_full  = dec_is_wr ? wr_full[iss_thread] : rd_full[iss_thread];
    assign iss_ready = room && !(|rd_iss_m) && !(|wr_iss_m) && !(dec.ok && tgt_full);

    // Oldest-first completion steering.
    logic rd_found, wr_found;
    logic [NSLOT-1:0] rd_pick, wr_pick;

    mt_oldest #(.N(NSLOT)) u_rd_pick (
        .cand  (rd_cpl_m & {NSLOT{rd_cpl_valid}}),
        .age   (rd_age),
        .found (rd_found),
        .pick  (rd_pick)
    );

    mt_oldest #(.N(NSLOT)) u_wr_pick (
        .cand  (wr_cpl_m & {NSLOT{wr_cpl_valid}}),
        .age   (wr_age),
        .found (wr_found),
        .pick  (wr_pick)
    );

    assign rd_ret = rd_pick;
    assign wr_ret = wr_pick;

    logic [TID_W-1:0] rd_sel_thr, wr_sel_thr;
    req_kind_e        rd_sel_kind, wr_sel_kind;
    logic             rd_sel_pf, wr_sel_pf;

    always_comb begin
        rd_sel_thr  = '0;
        rd_sel_kind = K_LOAD;
        rd_sel_pf   = 1'b0;
        wr_sel_thr  = '0;
        wr_sel_kind = K_STORE;
        wr_sel_pf   = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (rd_pick[t*ENTRIES + e]) begin
                    rd_sel_thr  = TID_W'(t);
                    rd_sel_kind = rd_kind[t][e];
                    rd_sel_pf   = rd_pf[t*ENTRIES + e];
                end
                if (wr_pick[t*ENTRIES + e]) begin
                    wr_sel_thr  = TID_W'(t);
                    wr_sel_kind = wr_kind[t][e];
                    wr_sel_pf   = wr_pf[t*ENTRIES + e];
                end
            end
        end
    end

    // Outstanding count.
    logic             inc;
    logic [1:0]       n_ret;
    logic [CNT_W-1:0] cnt_next;

    assign inc      = (|rd_alloc) || (|wr_alloc);
    assign n_ret    = {1'b0, rd_found} + {1'b0, wr_found};
    assign cnt_next = outstanding + CNT_W'(inc) - CNT_W'(n_ret);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q          <= '0;
            outstanding    <= '0;
            rd_resp_valid  <= 1'b0;
            rd_resp_thread <= '0;
            rd_resp_kind   <= '0;
            wr_resp_valid  <= 1'b0;
            wr_resp_thread <= '0;
            wr_resp_kind   <= '0;
            proto_err      <= 1'b0;
        end else begin
            now_q          <= now_q + TS_W'(1);
            outstanding    <= cnt_next;
            rd_resp_valid  <= rd_found && !rd_sel_pf;
            rd_resp_thread <= rd_sel_thr;
            rd_resp_kind   <= rd_sel_kind;
            wr_resp_valid  <= wr_found && !wr_sel_pf;
            wr_resp_thread <= wr_sel_thr;
            wr_resp_kind   <= wr_sel_kind;
            if ((rd_cpl_valid && !rd_found) || (wr_cpl_valid && !wr_found))
                proto_err <= 1'b1;
        end
    end

    mt_watchdog #(.N(2*NSLOT), .THRESH(DL_THRESH)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .arm_req   ((|rd_took) || (|wr_took)),
        .busy_next (cnt_next != '0),
        .live      ({wr_live, rd_live}),
        .age       (all_age),
        .deadlock  (deadlock)
    );

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        outstanding <= CNT_W'(MAX_OUT));

    p_cnt_up_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && !rd_found && !wr_found) |=> outstanding == $past(outstanding) + CNT_W'(1));

    p_cnt_down_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_found && !inc && !wr_found) |=> outstanding == $past(outstanding) - CNT_W'(1));

    p_pf_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_found && rd_sel_pf) |=> !rd_resp_valid);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    p_live_count_r5: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_live, wr_live}) == int'(outstanding));

endmodule

// File: tb/tb_miss_tracker.sv
module tb_miss_tracker;
    import mt_pkg::*;

    localparam int NT   = 2;
    localparam int ENT  = 4;
    localparam int MAXO = 5;
    localparam int TH   = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              iss_valid;
    logic [0:0]        iss_thread;
    logic              iss_fetch, iss_lock, iss_swap, iss_rd, iss_wr, iss_pf;
    logic [ADDR_W-1:0] iss_addr;
    logic              iss_ready;
    logic              rd_cpl_valid, wr_cpl_valid;
    logic [LINE_W-1:0] rd_cpl_line, wr_cpl_line;
    logic              rd_resp_valid, wr_resp_valid;
    logic [0:0]        rd_resp_thread, wr_resp_thread;
    logic [1:0]        rd_resp_kind, wr_resp_kind;
    logic [2:0]        outstanding;
    logic              deadlock, proto_err;

    miss_tracker #(.NUM_THREADS(NT), .ENTRIES(ENT), .MAX_OUT(MAXO), .DL_THRESH(TH)) dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_thread(iss_thread),
        .iss_fetch(iss_fetch), .iss_lock(iss_lock), .iss_swap(iss_swap),
        .iss_rd(iss_rd), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_pf(iss_pf),
        .iss_ready(iss_ready), .rd_cpl_valid(rd_cpl_valid), .rd_cpl_line(rd_cpl_line),
        .wr_cpl_valid(wr_cpl_valid), .wr_cpl_line(wr_cpl_line),
        .rd_resp_valid(rd_resp_valid), .rd_resp_thread(rd_resp_thread),
        .rd_resp_kind(rd_resp_kind), .wr_resp_valid(wr_resp_valid),
        .wr_resp_thread(wr_resp_thread), .wr_resp_kind(wr_resp_kind),
        .outstanding(outstanding), .deadlock(deadlock), .proto_err(proto_err)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] lineno(input logic [31:0] a);
        return LINE_W'(a / 64);
    endfunction

    task automatic clear_flags();
        iss_valid = 0; iss_fetch = 0; iss_lock = 0; iss_swap = 0;
        iss_rd = 0; iss_wr = 0; iss_pf = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; clear_flags(); rd_cpl_valid = 0; wr_cpl_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic issue(input int thr, input logic [4:0] fl, input logic [31:0] a, input logic pf);
        @(negedge clk);
        iss_valid = 1; iss_thread = thr[0];
        iss_fetch = fl[4]; iss_lock = fl[3]; iss_swap = fl[2]; iss_rd = fl[1]; iss_wr = fl[0];
        iss_addr = a; iss_pf = pf;
        @(negedge clk);
        clear_flags();
    endtask

    task automatic peek(input int thr, input logic wr, input logic [31:0] a, output logic rdy);
        iss_thread = thr[0]; iss_rd = !wr; iss_wr = wr; iss_addr = a; iss_valid = 0;
        #1 rdy = iss_ready;
        clear_flags();
    endtask

    task automatic cpl_rd(input logic [LINE_W-1:0] l);
        @(negedge clk); rd_cpl_valid = 1; rd_cpl_line = l;
        @(negedge clk); rd_cpl_valid = 0;
    endtask

    task automatic cpl_wr(input logic [LINE_W-1:0] l);
        @(negedge clk); wr_cpl_valid = 1; wr_cpl_line = l;
        @(negedge clk); wr_cpl_valid = 0;
    endtask

    localparam logic [4:0] F_LOAD  = 5'b00010;
    localparam logic [4:0] F_STORE = 5'b00001;
    localparam logic [4:0] F_ATOM  = 5'b01000;

    initial begin
        logic rdy;
        int   t0;
        rst = 1; clear_flags(); iss_thread = 0; iss_addr = 0;
        rd_cpl_valid = 0; wr_cpl_valid = 0; rd_cpl_line = 0; wr_cpl_line = 0;
        do_reset();

        // R10 reset state
        chk("R10 outstanding", 32'(outstanding), 0);
        peek(0, 0, 32'h100, rdy);
        chk("R10 ready", 32'(rdy), 1);
        chk("R10 rd_resp_valid", 32'(rd_resp_valid), 0);
        chk("R10 wr_resp_valid", 32'(wr_resp_valid), 0);
        chk("R10 deadlock", 32'(deadlock), 0);
        chk("R10 proto_err", 32'(proto_err), 0);

        // R1 sweep of all flag combinations
        for (int c = 0; c < 32; c++) begin
            logic [4:0]  fl;
            int          ek;
            logic [31:0] a;
            fl = c[4:0];
            if (fl[4])               ek = 1;
            else if (fl[3] | fl[2])  ek = 3;
            else if (fl[1])          ek = 0;
            else if (fl[0])          ek = 2;
            else                     ek = -1;
            a = 32'h0004_0000 + c * 64 + 5;
            issue(c % 2, fl, a, 0);
            if (ek < 0) begin
                chk("R1 no flag no insert", 32'(outstanding), 0);
            end else begin
                chk("R1 insert count", 32'(outstanding), 1);
                if (ek < 2) begin
                    cpl_rd(lineno(a));
                    chk("R1 read-table resp", 32'(rd_resp_valid), 1);
                    chk("R1 read kind", 32'(rd_resp_kind), 32'(ek));
                    chk("R6 read thread", 32'(rd_resp_thread), 32'(c % 2));
                end else begin
                    cpl_wr(lineno(a));
                    chk("R1 write-table resp", 32'(wr_resp_valid), 1);
                    chk("R1 write kind", 32'(wr_resp_kind), 32'(ek));
                    chk("R6 write thread", 32'(wr_resp_thread), 32'(c % 2));
                end
                chk("R6 count back to zero", 32'(outstanding), 0);
                chk("R1 no proto error", 32'(proto_err), 0);
            end
        end

        // R2 / R4 line matching and busy-line refusal
        issue(0, F_LOAD, 32'h1000_0025, 0);
        peek(1, 0, 32'h1000_0000, rdy);  chk("R4 same line other thread", 32'(rdy), 0);
        peek(0, 1, 32'h1000_003F, rdy);  chk("R2 top byte of line", 32'(rdy), 0);
        peek(0, 0, 32'h1000_0040, rdy);  chk("R2 next line free", 32'(rdy), 1);
        cpl_rd(lineno(32'h1000_0000));
        chk("R2 completion by line", 32'(rd_resp_valid), 1);

        // R5 overwrite keeps count; prefetch bit replaced
        do_reset();
        issue(0, F_LOAD, 32'h2000_0000, 0);
        issue(0, F_LOAD, 32'h2000_0010, 1);
        chk("R5 overwrite count", 32'(outstanding), 1);
        cpl_rd(lineno(32'h2000_0000));
        chk("R5 overwritten entry is prefetch", 32'(rd_resp_valid), 0);
        chk("R5 count after retire", 32'(outstanding), 0);

        // R6 oldest-first, both thread orders
        issue(1, F_LOAD, 32'h3000_0000, 0);
        repeat (3) @(negedge clk);
        issue(0, F_LOAD, 32'h3000_0000, 0);
        chk("R6 two entries", 32'(outstanding), 2);
        cpl_rd(lineno(32'h3000_0000));
        chk("R6 oldest thread1 first", 32'(rd_resp_thread), 1);
        cpl_rd(lineno(32'h3000_0000));
        chk("R6 then thread0", 32'(rd_resp_thread), 0);
        chk("R6 then valid", 32'(rd_resp_valid), 1);
        issue(0, F_STORE, 32'h3100_0000, 0);
        repeat (2) @(negedge clk);
        issue(1, F_ATOM, 32'h3100_0000, 0);
        cpl_wr(lineno(32'h3100_0000));
        chk("R6 oldest thread0 first", 32'(wr_resp_thread), 0);
        chk("R6 store kind", 32'(wr_resp_kind), 2);
        cpl_wr(lineno(32'h3100_0000));
        chk("R6 then thread1", 32'(wr_resp_thread), 1);
        chk("R6 atomic kind", 32'(wr_resp_kind), 3);
        chk("R6 count zero", 32'(outstanding), 0);

        // R7 prefetch retire without response
        issue(1, F_STORE, 32'h4000_0000, 1);
        cpl_wr(lineno(32'h4000_0000));
        chk("R7 no response for prefetch", 32'(wr_resp_valid), 0);
        chk("R7 count dropped", 32'(outstanding), 0);

        // R3 table full and global cap
        do_reset();
        for (int i = 0; i < 4; i++) issue(0, F_LOAD, 32'h5000_0000 + i * 64, 0);
        peek(0, 0, 32'h5100_0000, rdy); chk("R3 full table not ready", 32'(rdy), 0);
        peek(1, 0, 32'h5100_0000, rdy); chk("R3 other table ready", 32'(rdy), 1);
        issue(0, F_LOAD, 32'h5100_0000, 0);
        chk("R3 full table drops insert", 32'(outstanding), 4);
        issue(1, F_STORE, 32'h5200_0000, 0);
        chk("R3 count at cap", 32'(outstanding), 5);
        peek(1, 0, 32'h5300_0000, rdy); chk("R3 not ready at cap", 32'(rdy), 0);
        issue(1, F_LOAD, 32'h5300_0000, 0);
        chk("R3 insert dropped at cap", 32'(outstanding), 5);
        cpl_wr(lineno(32'h5200_0000));
        chk("R3 count after retire", 32'(outstanding), 4);
        peek(1, 0, 32'h5300_0000, rdy); chk("R3 ready again", 32'(rdy), 1);

        // R9 unmatched completions
        do_reset();
        cpl_rd(lineno(32'h6000_0000));
        chk("R9 err on empty", 32'(proto_err), 1);
        chk("R9 no resp", 32'(rd_resp_valid), 0);
        do_reset();
        issue(0, F_STORE, 32'h6100_0000, 0);
        cpl_rd(lineno(32'h6100_0000));
        chk("R9 wrong channel err", 32'(proto_err), 1);
        chk("R9 count unchanged", 32'(outstanding), 1);
        cpl_wr(lineno(32'h6100_0000));
        chk("R9 entry intact", 32'(wr_resp_valid), 1);

        // R8 entry held exactly one period
        do_reset();
        issue(0, F_LOAD, 32'h7000_0000, 0);
        t0 = cyc;
        while (cyc < t0 + TH - 2) @(negedge clk);
        chk("R8 before period", 32'(deadlock), 0);
        while (cyc < t0 + TH + 2) @(negedge clk);
        chk("R8 after period", 32'(deadlock), 1);

        // R8 younger entry trips only after re-arm
        do_reset();
        issue(0, F_LOAD, 32'h7100_0000, 0);
        t0 = cyc;
        repeat (8) @(negedge clk);
        issue(1, F_STORE, 32'h7200_0000, 0);
        cpl_rd(lineno(32'h7100_0000));
        while (cyc < t0 + TH + 3) @(negedge clk);
        chk("R8 young entry first period", 32'(deadlock), 0);
        while (cyc < t0 + 2 * TH + 3) @(negedge clk);
        chk("R8 young entry after rearm", 32'(deadlock), 1);

        // R8 quick retire never trips
        do_reset();
        issue(0, F_LOAD, 32'h7300_0000, 0);
        cpl_rd(lineno(32'h7300_0000));
        repeat (3 * TH) @(negedge clk);
        chk("R8 idle after disarm", 32'(deadlock), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule